// File: doc/BRIEF.md
# Scaler Line and Frame Sync Generator

This block drives the two sync strobes that go with an output pixel stream towards a scaler. It reads a pixel counter that steps through each output line, together with the total line length, and uses them to place a horizontal sync pulse. That pulse ends exactly when the counter returns to pixel 0. A larger programmed width moves only its start earlier. The usable width depends on the output format. Plain 24-bit colour uses the width as programmed. The 24-bit luma/chroma format rounds it up to an odd count. The double-width (48-bit) format rounds it down to an even count, because that format steps in pairs of pixel clocks.

The vertical sync output follows an incoming vertical sync level that has already been synchronised. It changes only at pixel 7 of a line, so its width in lines equals the width of the incoming pulse. Each output has its own polarity bit. Width, format and horizontal polarity are taken up at the start of a line. The vertical polarity is taken up at the pixel-7 update. A mid-line change therefore never cuts a pulse short.

Top module: `scaler_sync_gen`

## Requirements
- R1: While the pixel counter is 0, the horizontal output is inactive, so its trailing edge always falls at pixel 0.
- R2: The horizontal output is active for counter value p exactly when the effective width e is nonzero and p + e >= line_len. An effective width of 0 gives no pulse.
- R3: When wide_mode=0 and yuv_mode=0, the effective width equals hs_width (0 to 7).
- R4: When wide_mode=0 and yuv_mode=1, the effective width is 0 for hs_width=0 and otherwise hs_width with bit 0 forced to 1 (2 gives 3, 4 gives 5, 6 gives 7).
- R5: When wide_mode=1, whatever yuv_mode is, the effective width is hs_width with bit 0 cleared (1 gives 0, 3 gives 2, 7 gives 6).
- R6: hs_pol=1 makes the horizontal output active-high. hs_pol=0 makes it active-low.
- R7: The vertical output changes only after the counter reads 7. At that point it takes the vsync_lvl value present in the same cycle and holds it until the next time the counter reads 7.
- R8: vs_pol=1 makes the vertical output active-high. vs_pol=0 makes it active-low.
- R9: While rst_n is low (synchronous), both outputs sit at the inactive level given by their polarity inputs.
- R10: hs_width, wide_mode, yuv_mode and hs_pol are sampled when the counter reads 0 and hold for that whole line. vs_pol is sampled when the counter reads 7.
- R11: Both outputs are registered. The value seen after a clock edge reflects the counter value presented at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_cnt | input | CW | Current pixel index within the line |
| line_len | input | CW | Total pixels per line |
| vsync_lvl | input | 1 | Synchronised incoming vertical sync, active high |
| hs_width | input | WW | Programmed horizontal pulse width |
| hs_pol | input | 1 | Horizontal polarity, 1 = active-high |
| vs_pol | input | 1 | Vertical polarity, 1 = active-high |
| wide_mode | input | 1 | Double-width output format |
| yuv_mode | input | 1 | Luma/chroma input format |
| hsout | output | 1 | Horizontal sync output |
| vsout | output | 1 | Vertical sync output |

## Verification
A wrong latched width or polarity shows at the horizontal output within one line. The pulse then starts at the wrong pixel or sits at the wrong level, and the last pixels before the wrap show it first. A vertical state that is updated at the wrong pixel, or that samples the wrong level, shows as an edge on the vertical output at some pixel other than 7, or as an edge missing when the next line reaches pixel 7. The sweep steps through every format, width and polarity for one line each. Within each line it toggles the incoming vertical level and the configuration away from their sampling points, so an early or late capture gives a wrong value before that line ends.

// File: rtl/scaler_sync_gen.sv
module scaler_sync_gen #(
  parameter int CW = 11,
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pix_cnt,
  input  logic [CW-1:0] line_len,
  input  logic          vsync_lvl,
  input  logic [WW-1:0] hs_width,
  input  logic          hs_pol,
  input  logic          vs_pol,
  input  logic          wide_mode,
  input  logic          yuv_mode,
  output logic          hsout,
  output logic          vsout
);
  localparam int SW = CW + 1;
  localparam logic [CW-1:0] VS_PIX = CW'(7);

  logic [WW-1:0] w_live, w_q, w_use;
  logic          hpol_q, vpol_q, hpol_use;
  logic          hs_act, vs_act, hs_hit;
  logic          line_start, vs_pt;

  assign line_start = (pix_cnt == '0);
  assign vs_pt      = (pix_cnt == VS_PIX);

  always_comb begin
    if (wide_mode)
      w_live = {hs_width[WW-1:1], 1'b0};
    else if (yuv_mode && hs_width != '0)
      w_live = hs_width | WW'(1);
    else
      w_live = hs_width;
  end

  assign w_use    = line_start ? w_live : w_q;
  assign hpol_use = line_start ? hs_pol : hpol_q;
  assign hs_hit   = (w_use != '0) &&
                    (({1'b0, pix_cnt} + SW'(w_use)) >= {1'b0, line_len});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q    <= w_live;
      hpol_q <= hs_pol;
      vpol_q <= vs_pol;
      hs_act <= 1'b0;
      vs_act <= 1'b0;
    end else begin
      w_q    <= w_use;
      hpol_q <= hpol_use;
      hs_act <= hs_hit;
      if (vs_pt) begin
        vs_act <= vsync_lvl;
        vpol_q <= vs_pol;
      end
    end
  end

  assign hsout = hs_act ~^ hpol_q;
  assign vsout = vs_act ~^ vpol_q;

  // R1: pixel 0 always ends the pulse
  p_trail_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (hsout == !hpol_q));

  // R2: a zero effective width never asserts the output
  p_zero_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && w_q == '0) |=> (hsout == !hpol_q));

  // R5: wide format always latches an even width
  p_wide_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && wide_mode) |=> !w_q[0]);

  // R7: the vertical output moves only after pixel 7
  p_vs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_pt |=> $stable(vsout));

  // R8: the vertical output takes the sampled level in the chosen polarity
  p_vs_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vs_pt |=> (vsout == ($past(vsync_lvl) ~^ $past(vs_pol))));

  // R10: the latched horizontal configuration holds through the line
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> ($stable(w_q) && $stable(hpol_q)));
endmodule

// File: tb/scaler_sync_gen_tb.sv
module scaler_sync_gen_tb;
  localparam int CLK_NS = 10;
  localparam int CW = 8;
  localparam int WW = 3;
  localparam int LEN = 20;
  localparam int NLINES = 65;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] pix_cnt = '0;
  logic [CW-1:0] line_len = CW'(LEN);
  logic          vsync_lvl = 1'b0;
  logic [WW-1:0] hs_width = '0;
  logic          hs_pol = 1'b0, vs_pol = 1'b0, wide_mode = 1'b0, yuv_mode = 1'b0;
  logic          hsout, vsout;

  int vectors = 0;
  int fails = 0;

  int  m_w;
  logic m_hpol, m_vpol, m_vact;

  scaler_sync_gen #(.CW(CW), .WW(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .line_len(line_len),
    .vsync_lvl(vsync_lvl), .hs_width(hs_width), .hs_pol(hs_pol),
    .vs_pol(vs_pol), .wide_mode(wide_mode), .yuv_mode(yuv_mode),
    .hsout(hsout), .vsout(vsout));

  always #(CLK_NS/2) clk = ~clk;

  function automatic int eff_width(int w, logic wide, logic yuv);
    if (wide) return (w / 2) * 2;
    if (yuv && w != 0) return (w % 2 == 1) ? w : w + 1;
    return w;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (pix %0d)", tag, act, exp, pix_cnt);
    end
  endtask

  task automatic set_cfg(int combo);
    hs_width  = WW'(combo % 8);
    hs_pol    = ((combo / 8) % 2) == 1;
    wide_mode = ((combo / 16) % 4) >= 2;
    yuv_mode  = ((combo / 16) % 2) == 1;
  endtask

  // drives p at a falling edge, checks one cycle later (R11 latency)
  task automatic step(int p);
    logic exp_act;
    string tag;
    pix_cnt = CW'(p);
    if (p == 0) begin
      m_w = eff_width(int'(hs_width), wide_mode, yuv_mode);
      m_hpol = hs_pol;
    end
    if (p == 7) begin
      m_vact = vsync_lvl;
      m_vpol = vs_pol;
    end
    exp_act = (m_w != 0) && (p + m_w >= LEN);
    @(posedge clk);
    @(negedge clk);
    if (p == 0) tag = "R1/R11";
    else tag = "R2/R6/R10";
    tag = {tag, wide_mode ? "/R5" : (yuv_mode ? "/R4" : "/R3")};
    check(tag, hsout, exp_act ? m_hpol : !m_hpol);
    check((p == 7) ? "R7/R8/R10" : "R7", vsout, m_vact ? m_vpol : !m_vpol);
  endtask

  task automatic do_reset(logic hp, logic vp);
    @(negedge clk);
    rst_n = 1'b0;
    hs_pol = hp;
    vs_pol = vp;
    repeat (3) @(negedge clk);
    check("R9 hs", hsout, !hp);
    check("R9 vs", vsout, !vp);
    m_w = eff_width(int'(hs_width), wide_mode, yuv_mode);
    m_hpol = hp;
    m_vpol = vp;
    m_vact = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    set_cfg(0);
    do_reset(1'b1, 1'b1);
    do_reset(1'b0, 1'b0);
    set_cfg(0);
    do_reset(1'b0, 1'b1);
    for (int ln = 0; ln < NLINES; ln++) begin
      for (int p = 0; p < LEN; p++) begin
        if (p == 2) vsync_lvl = (ln % 5) < 2;
        if (p == 3) vs_pol = (((ln / 4) + (ln / 16)) % 2) == 0;
        if (p == 10) set_cfg(ln + 1);
        if (p == 12) vsync_lvl = !vsync_lvl;
        step(p);
      end
    end
    do_reset(1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule